// File: doc/BRIEF.md
# Sticky Multithread Issue Selector

This block decides, once per clock, which of up to four hardware thread contexts owns the single shared decode and dispatch slot of a multithreaded vector core. Only one thread is examined in any cycle. The block offers that thread's next instruction through a valid/ready pair. `issue_valid` says a thread is being examined and `sel_tid` names it. `issue_ready` is the downstream answer for that same cycle: it says whether the instruction can go this cycle. A transfer happens when both are high, and it is flagged on `dispatch_fire`. When `issue_ready` is low with `issue_valid` high, the thread is blocked (a data dependency or a busy unit), the cycle is lost, and nothing is held over. The offer is recomputed in the next cycle, and a consumer must not expect it to persist.

Selection is sticky, not round-robin. A thread keeps the slot while its instructions keep dispatching, so back-to-back dependent vector instructions from it can chain. When the thread blocks or runs out of instructions, the slot falls back to the lowest-numbered thread that has a valid instruction. The thread that just blocked is passed over for exactly one cycle. Instructions within a thread therefore leave in order, and at most one instruction leaves per cycle.

Top module: `mt_issue_selector`

## Requirements
- R1: During reset and after it, the sticky pointer is thread 0 and no thread is marked blocked. With every thread valid and `issue_ready` high in the first cycle, thread 0 is examined and dispatched.
- R2: `dispatch_fire` is high only in a cycle where `issue_valid` and `issue_ready` are both high. At most one instruction dispatches per cycle.
- R3: If the examined thread dispatched in the previous cycle and still has a valid instruction, it is examined again. This holds even when a lower-numbered thread is also valid.
- R4: If the examined thread is offered with `issue_ready` low, nothing dispatches. In the next cycle a different thread is examined, or none at all.
- R5: When the sticky thread is not eligible, the examined thread is the lowest-numbered eligible thread. A thread is eligible when its `thr_valid` bit (bit i for thread i) is high and it was not blocked in the previous cycle.
- R6: A thread whose `thr_valid` bit is low is never examined.
- R7: With no eligible thread, `issue_valid` and `dispatch_fire` stay low whatever `issue_ready` does, and `sel_tid` shows the sticky pointer.
- R8: An idle cycle leaves the sticky pointer unchanged. A block excludes its thread for one cycle only, so a lone blocked thread is idle for one cycle and is then examined again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_valid | input | NUM_THREADS | Bit i high: thread i has an instruction ready to decode |
| issue_ready | input | 1 | The examined thread's instruction can dispatch this cycle |
| issue_valid | output | 1 | A thread is being examined this cycle |
| sel_tid | output | TID_W | Examined thread, or the sticky pointer when idle |
| dispatch_fire | output | 1 | One instruction from `sel_tid` dispatches this cycle |

## Verification
`issue_valid`, `sel_tid` and `dispatch_fire` follow `thr_valid` and `issue_ready` within the same cycle. Each decision, whether a dispatch, a block or an idle cycle, shapes the choice one clock later through the sticky pointer and the one-cycle exclusion. The bench changes inputs on the falling edge and reads the outputs one time unit later, before the next rising edge. Each check therefore sees the combinational result of the current inputs together with the state left by the previous cycle. Scenarios are chained so that the expected state carried into each step is known.

// File: rtl/mt_sel_pkg.sv
package mt_sel_pkg;
  localparam int unsigned MAX_CTX = 4;

  typedef enum logic [1:0] {
    PICK_NONE     = 2'd0,
    PICK_STICKY   = 2'd1,
    PICK_FALLBACK = 2'd2
  } pick_kind_e;
endpackage

// File: rtl/mts_lowest_pick.sv
module mts_lowest_pick #(
  parameter int unsigned N = 4,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  logic [N:0]   seen;
  logic [N-1:0] grant;

  assign seen[0] = 1'b0;

  // Priority chain: a request wins only if no lower index requested.
  for (genvar g = 0; g < N; g++) begin : g_chain
    assign grant[g]  = req[g] & ~seen[g];
    assign seen[g+1] = seen[g] | req[g];
  end

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | i[W-1:0];
    end
  end
endmodule

// File: rtl/mts_eligibility.sv
module mts_eligibility #(
  parameter int unsigned N = 4,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] thr_valid,
  input  logic [N-1:0] blocked_oh,
  input  logic [W-1:0] sticky_tid,
  output logic [N-1:0] elig,
  output logic         sticky_ok
);
  assign elig = thr_valid & ~blocked_oh;

  always_comb begin
    sticky_ok = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sticky_tid == i[W-1:0]) sticky_ok = elig[i];
    end
  end
endmodule

// File: rtl/mts_ctx_state.sv
module mts_ctx_state #(
  parameter int unsigned N = 4,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         ready,
  input  logic [W-1:0] pick_tid,
  output logic [W-1:0] sticky_tid,
  output logic [N-1:0] blocked_oh
);
  logic [N-1:0] pick_oh;

  always_comb begin
    pick_oh = '0;
    for (int i = 0; i < N; i++) begin
      if (pick_tid == i[W-1:0]) pick_oh[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_tid <= '0;
      blocked_oh <= '0;
    end else begin
      if (active) sticky_tid <= pick_tid;
      blocked_oh <= (active && !ready) ? pick_oh : '0;
    end
  end
endmodule

// File: rtl/mt_issue_selector.sv
module mt_issue_selector
  import mt_sel_pkg::*;
#(
  parameter int unsigned NUM_THREADS = MAX_CTX,
  localparam int unsigned TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] thr_valid,
  input  logic                   issue_ready,
  output logic                   issue_valid,
  output logic [TID_W-1:0]       sel_tid,
  output logic                   dispatch_fire
);
  logic [TID_W-1:0]       sticky_tid;
  logic [NUM_THREADS-1:0] blocked_oh;
  logic [NUM_THREADS-1:0] elig;
  logic                   sticky_ok;
  logic                   fb_any;
  logic [TID_W-1:0]       fb_tid;
  pick_kind_e             kind;

  mts_eligibility #(.N(NUM_THREADS)) u_elig (
    .thr_valid (thr_valid),
    .blocked_oh(blocked_oh),
    .sticky_tid(sticky_tid),
    .elig      (elig),
    .sticky_ok (sticky_ok)
  );

  mts_lowest_pick #(.N(NUM_THREADS)) u_pick (
    .req(elig),
    .any(fb_any),
    .idx(fb_tid)
  );

  always_comb begin
    if (sticky_ok)   kind = PICK_STICKY;
    else if (fb_any) kind = PICK_FALLBACK;
    else             kind = PICK_NONE;
  end

  always_comb begin
    unique case (kind)
      PICK_STICKY:   sel_tid = sticky_tid;
      PICK_FALLBACK: sel_tid = fb_tid;
      default:       sel_tid = sticky_tid;
    endcase
  end

  assign issue_valid   = (kind != PICK_NONE);
  assign dispatch_fire = issue_valid & issue_ready;

  mts_ctx_state #(.N(NUM_THREADS)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (issue_valid),
    .ready     (issue_ready),
    .pick_tid  (sel_tid),
    .sticky_tid(sticky_tid),
    .blocked_oh(blocked_oh)
  );
endmodule

// File: rtl/mt_issue_selector_chk.sv
module mt_issue_selector_chk #(
  parameter int unsigned NUM_THREADS = 4,
  localparam int unsigned TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_THREADS-1:0] thr_valid,
  input logic                   issue_ready,
  input logic                   issue_valid,
  input logic [TID_W-1:0]       sel_tid,
  input logic                   dispatch_fire
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R2
  no_fire_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_ready |-> !dispatch_fire);

  // R6
  valid_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> thr_valid[sel_tid]);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_valid == '0) |-> (!issue_valid && !dispatch_fire));

  // R3
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(dispatch_fire) && thr_valid[$past(sel_tid)])
      |-> (issue_valid && sel_tid == $past(sel_tid)));

  // R4
  block_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(issue_valid && !issue_ready) && issue_valid)
      |-> (sel_tid != $past(sel_tid)));
endmodule

bind mt_issue_selector mt_issue_selector_chk #(.NUM_THREADS(NUM_THREADS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .thr_valid    (thr_valid),
  .issue_ready  (issue_ready),
  .issue_valid  (issue_valid),
  .sel_tid      (sel_tid),
  .dispatch_fire(dispatch_fire)
);

// File: tb/mt_issue_selector_tb.sv
module mt_issue_selector_tb_top;
  localparam int CLK_P = 10;
  localparam int NT    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] thr_valid = '0;
  logic          issue_ready = 1'b0;
  logic          issue_valid;
  logic [1:0]    sel_tid;
  logic          dispatch_fire;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mt_issue_selector #(.NUM_THREADS(NT)) dut_i (
    .clk(clk), .rst_n(rst_n), .thr_valid(thr_valid), .issue_ready(issue_ready),
    .issue_valid(issue_valid), .sel_tid(sel_tid), .dispatch_fire(dispatch_fire)
  );

  task automatic cmp(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic expect_out(input string rq, input bit ev, input int et, input bit ef);
    cmp(rq, "issue_valid", int'(issue_valid), int'(ev));
    cmp(rq, "sel_tid", int'(sel_tid), et);
    cmp(rq, "dispatch_fire", int'(dispatch_fire), int'(ef));
  endtask

  task automatic step(input logic [NT-1:0] v, input logic r, input string rq,
                      input bit ev, input int et, input bit ef);
    @(negedge clk);
    thr_valid   = v;
    issue_ready = r;
    #1;
    expect_out(rq, ev, et, ef);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; thr_valid = '0; issue_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    expect_out("R1", 1'b0, 0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(4'b1111, 1'b1, "R1", 1'b1, 0, 1'b1);
  endtask

  task automatic t_sticky;
    step(4'b1111, 1'b1, "R3", 1'b1, 0, 1'b1);
    step(4'b1110, 1'b1, "R6", 1'b1, 1, 1'b1);
    step(4'b1111, 1'b1, "R3", 1'b1, 1, 1'b1);
  endtask

  task automatic t_block;
    step(4'b1111, 1'b0, "R2", 1'b1, 1, 1'b0);
    step(4'b1111, 1'b1, "R4", 1'b1, 0, 1'b1);
    step(4'b1111, 1'b0, "R2", 1'b1, 0, 1'b0);
    step(4'b1111, 1'b1, "R5", 1'b1, 1, 1'b1);
  endtask

  task automatic t_idle;
    step(4'b0000, 1'b1, "R7", 1'b0, 1, 1'b0);
    step(4'b1011, 1'b1, "R8", 1'b1, 1, 1'b1);
  endtask

  task automatic t_lone_block;
    step(4'b0010, 1'b0, "R4", 1'b1, 1, 1'b0);
    step(4'b0010, 1'b1, "R8", 1'b0, 1, 1'b0);
    step(4'b0010, 1'b1, "R8", 1'b1, 1, 1'b1);
  endtask

  task automatic t_high_fallback;
    step(4'b1010, 1'b0, "R4", 1'b1, 1, 1'b0);
    step(4'b1010, 1'b1, "R5", 1'b1, 3, 1'b1);
    step(4'b1011, 1'b1, "R3", 1'b1, 3, 1'b1);
  endtask

  initial begin
    t_reset();
    t_sticky();
    t_block();
    t_idle();
    t_lone_block();
    t_high_fallback();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule